// File: doc/BRIEF.md
# Multiplexed Address Latch and Chip-Select Decoder

This block sits on a CPU address bus that carries the high and low address bytes on the same wires at different times. While a latch strobe is high the six high-byte lines pass straight to the outputs. When the strobe falls, their values are captured and held. The low four lines become address bits 8 to 11 for the memory array. The upper two lines choose one of four active-low chip selects, each covering a 4K-byte region, so 16K bytes are decoded in total. With 2K-byte parts the same block covers 8K bytes.

A chip enable gates the selects. A build-time parameter picks one of two variants. In the gated variant the selects are also qualified by the memory read and write strobes, which keeps RAMs that have no output enable off the bus. In the ungated variant the chip enable alone qualifies the selects. Gating acts on the live control inputs and is never captured by the latch. If the strobe is tied high the block follows its inputs, which serves a non-multiplexed bus.

The transparent latch is modelled synchronously. A register loads on every system clock edge at which the strobe is high. The outputs show the live inputs while the strobe is high and the register contents otherwise.

Top module: `addr_latch_decoder`

## Requirements
- R1: While strobe_i is high, addr_o equals addr_i[3:0] and the select index equals addr_i[5:4] in the same cycle, with no clock delay.
- R2: While strobe_i is low, addr_o and the select index hold the addr_i value present at the last clock edge at which strobe_i was high, whatever addr_i does.
- R3: addr_i[3:0] maps bit for bit onto addr_o[3:0], which stand for address bits 8 to 11.
- R4: When enabled, index k = addr_i[5:4] (latched or flowing) drives cs_no[k] low, and the other three selects are high.
- R5: A high ce_ni drives all four cs_no bits high, whatever the other inputs are.
- R6: With GATED_RW=1 the selects are enabled only when ce_ni is low and at least one of rd_ni and wr_ni is low. With both strobes high, all cs_no bits are high.
- R7: With GATED_RW=0, rd_ni and wr_ni have no effect, and a low ce_ni alone enables the decode.
- R8: With strobe_i held high across many cycles, the outputs follow every new addr_i value in the cycle it is applied (data-following mode).
- R9: An asserted rst_ni clears the held address and index to zero. With strobe_i low afterwards, addr_o is 0 and only cs_no[0] can go low.
- R10: Changes on ce_ni, rd_ni and wr_ni take effect on cs_no in the same cycle, including while the address is held.

Parameters: ADDR_W (latched address bits, default 4), SEL_W (select index bits, default 2), GATED_RW (1 gives the gated variant).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock that samples the strobe |
| rst_ni | input | 1 | Asynchronous reset, active low |
| strobe_i | input | 1 | Latch control: high passes the inputs through, low holds them |
| addr_i | input | 6 | Multiplexed high-byte address lines |
| ce_ni | input | 1 | Chip enable, active low |
| rd_ni | input | 1 | Memory read strobe, active low (ignored when GATED_RW=0) |
| wr_ni | input | 1 | Memory write strobe, active low (ignored when GATED_RW=0) |
| addr_o | output | 4 | Latched address bits 8 to 11 |
| cs_no | output | 4 | Decoded chip selects, active low |

## Verification
Every output is due in the same cycle as its stimulus, because the flow-through path and the gating are combinational. The only registered effect is the held value, which depends on the last clock edge at which the strobe was high. The bench applies its inputs 1 ns after a rising edge and samples 2 ns later, well before the next edge. Its model updates the held value only after each check, to mirror the edge that follows. A gated instance and an ungated instance see the same stimulus, so every control combination is checked against both variants.

// File: rtl/alcd_pkg.sv
`timescale 1ns/1ps
package alcd_pkg;
  localparam int unsigned DEF_ADDR_W = 4;
  localparam int unsigned DEF_SEL_W  = 2;
endpackage

// File: rtl/alcd_latch.sv
`timescale 1ns/1ps
module alcd_latch #(
  parameter int unsigned W = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         strobe_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] held_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       held_q <= '0;
    else if (strobe_i) held_q <= d_i;
  end

  // transparent while strobe high, register contents otherwise
  assign q_o = strobe_i ? d_i : held_q;

  // R2
  hold_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(strobe_i) && !strobe_i) |-> $stable(q_o));

  // R2
  capture_on_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $fell(strobe_i)) |-> (q_o == $past(d_i)));
endmodule

// File: rtl/alcd_decode.sv
`timescale 1ns/1ps
module alcd_decode #(
  parameter int unsigned SEL_W  = 2,
  localparam int unsigned NUM_CS = 1 << SEL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SEL_W-1:0]  sel_i,
  output logic [NUM_CS-1:0] hot_o
);
  for (genvar k = 0; k < NUM_CS; k++) begin : g_hot
    assign hot_o[k] = (sel_i == SEL_W'(k));
  end

  // R4
  one_hot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(hot_o) == 1);
endmodule

// File: rtl/alcd_gate.sv
`timescale 1ns/1ps
module alcd_gate #(
  parameter int unsigned NUM_CS   = 4,
  parameter bit          GATED_RW = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CS-1:0] hot_i,
  input  logic              ce_ni,
  input  logic              rd_ni,
  input  logic              wr_ni,
  output logic [NUM_CS-1:0] cs_no
);
  logic en;

  if (GATED_RW) begin : g_rw
    assign en = !ce_ni && (!rd_ni || !wr_ni);
    // R6
    rw_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_ni && wr_ni) |-> (&cs_no));
  end else begin : g_ce
    assign en = !ce_ni;
    // R7
    ce_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !ce_ni |-> ($countones(~cs_no) == 1));
  end

  assign cs_no = en ? ~hot_i : '1;

  // R5
  ce_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_ni |-> (&cs_no));
endmodule

// File: rtl/addr_latch_decoder.sv
`timescale 1ns/1ps
module addr_latch_decoder
  import alcd_pkg::*;
#(
  parameter int unsigned ADDR_W   = DEF_ADDR_W,
  parameter int unsigned SEL_W    = DEF_SEL_W,
  parameter bit          GATED_RW = 1'b1,
  localparam int unsigned IN_W    = ADDR_W + SEL_W,
  localparam int unsigned NUM_CS  = 1 << SEL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              strobe_i,
  input  logic [IN_W-1:0]   addr_i,
  input  logic              ce_ni,
  input  logic              rd_ni,
  input  logic              wr_ni,
  output logic [ADDR_W-1:0] addr_o,
  output logic [NUM_CS-1:0] cs_no
);
  logic [IN_W-1:0]   lat;
  logic [NUM_CS-1:0] hot;

  alcd_latch #(.W(IN_W)) u_latch (
    .clk_i(clk_i), .rst_ni(rst_ni), .strobe_i(strobe_i), .d_i(addr_i), .q_o(lat)
  );

  alcd_decode #(.SEL_W(SEL_W)) u_decode (
    .clk_i(clk_i), .rst_ni(rst_ni), .sel_i(lat[IN_W-1:ADDR_W]), .hot_o(hot)
  );

  alcd_gate #(.NUM_CS(NUM_CS), .GATED_RW(GATED_RW)) u_gate (
    .clk_i(clk_i), .rst_ni(rst_ni), .hot_i(hot), .ce_ni(ce_ni),
    .rd_ni(rd_ni), .wr_ni(wr_ni), .cs_no(cs_no)
  );

  assign addr_o = lat[ADDR_W-1:0];

  // R4
  single_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(~cs_no) <= 1);

  // R1
  flow_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_i |-> (addr_o == addr_i[ADDR_W-1:0]));
endmodule

// File: tb/addr_latch_decoder_bench.sv
`timescale 1ns/1ps
module addr_latch_decoder_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       strobe = 1'b0;
  logic [5:0] addr = '0;
  logic       ce_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [3:0] a_g, a_u, cs_g, cs_u;
  int total = 0, bad = 0;
  logic [5:0] m_held = '0;

  always #2.5 clk = ~clk;

  addr_latch_decoder u_addr_latch_decoder (
    .clk_i(clk), .rst_ni(rst_n), .strobe_i(strobe), .addr_i(addr),
    .ce_ni(ce_n), .rd_ni(rd_n), .wr_ni(wr_n), .addr_o(a_g), .cs_no(cs_g));

  addr_latch_decoder #(.GATED_RW(1'b0)) u_addr_latch_decoder_ungated (
    .clk_i(clk), .rst_ni(rst_n), .strobe_i(strobe), .addr_i(addr),
    .ce_ni(ce_n), .rd_ni(rd_n), .wr_ni(wr_n), .addr_o(a_u), .cs_no(cs_u));

  function automatic logic [5:0] eff_addr();
    return strobe ? addr : m_held;
  endfunction

  function automatic logic [3:0] exp_cs(input bit gated);
    logic [5:0] e = eff_addr();
    logic en = !ce_n && (!gated || !rd_n || !wr_n);
    return en ? ~(4'b0001 << e[5:4]) : 4'hF;
  endfunction

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // apply inputs after an edge, check mid-cycle, then mirror the coming edge
  task automatic step(input string tag, input logic s, input logic [5:0] a,
                      input logic ce, input logic rd, input logic wr);
    @(posedge clk); #1;
    strobe = s; addr = a; ce_n = ce; rd_n = rd; wr_n = wr;
    #2;
    chk({tag, " addr gated"}, a_g, eff_addr() & 6'h0F);
    chk({tag, " addr ungated"}, a_u, eff_addr() & 6'h0F);
    chk({tag, " cs gated"}, cs_g, exp_cs(1'b1));
    chk({tag, " cs ungated"}, cs_u, exp_cs(1'b0));
    if (s && rst_n) m_held = a;
  endtask

  initial begin
    #750000;
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h1D2C3B4A));
    // R9 reset state
    #3;
    chk("R9 reset addr", a_g, 4'h0);
    chk("R9 reset cs", cs_g, 4'hF);
    @(posedge clk); #1 rst_n = 1'b1;
    step("R9 idle after reset", 1'b0, 6'h3F, 1'b0, 1'b0, 1'b1);

    // R1 R2 R3 multiplexed sequence: high byte with strobe high, fall, change inputs
    step("R1 R3 present", 1'b1, 6'b10_1011, 1'b0, 1'b0, 1'b1);
    step("R2 hold after fall", 1'b0, 6'b01_0100, 1'b0, 1'b0, 1'b1);
    step("R2 hold keeps", 1'b0, 6'b11_1111, 1'b0, 1'b1, 1'b0);

    // R4 R5 R6 R7 R10 every index under every ce/rd/wr combination, address held
    for (int k = 0; k < 4; k++) begin
      step("R4 load index", 1'b1, {k[1:0], 4'h5}, 1'b1, 1'b1, 1'b1);
      for (int c = 0; c < 8; c++)
        step("R4 R5 R6 R7 R10 gating", 1'b0, 6'h2A ^ 6'(c), c[2], c[1], c[0]);
    end

    // R8 data-following
    for (int i = 0; i < 200; i++)
      step("R8 follow", 1'b1, 6'($urandom), 1'b0, 1'($urandom), 1'($urandom));

    // R9 reset mid-run clears the held value
    step("R9 preload", 1'b1, 6'h3E, 1'b0, 1'b0, 1'b0);
    @(posedge clk); #1 strobe = 1'b0; rst_n = 1'b0; m_held = '0;
    #1;
    chk("R9 mid reset addr", a_g, 4'h0);
    @(posedge clk); #1 rst_n = 1'b1;
    step("R9 after mid reset", 1'b0, 6'h3F, 1'b0, 1'b1, 1'b0);

    // mixed random
    for (int i = 0; i < 3000; i++)
      step("R1 R2 R4 R6 R7 random", 1'($urandom_range(0, 2) == 0), 6'($urandom),
           1'($urandom_range(0, 3) == 0), 1'($urandom), 1'($urandom));

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule